// File: doc/BRIEF.md
# Power-Fail Protected Byte-Wide SRAM

This block is a byte-wide static RAM with the three usual active-low strobes: chip select, output enable and write enable. It also has a supply supervisor. The strobes, the address and the incoming data byte pass through a clock-domain synchroniser. The block decodes standby, write, read and an active-but-quiet mode from the synchronised strobes. It writes the captured byte into a small register array, and it presents read data on a data-out / output-enable pair that a pad ring turns into a tri-state bus.

Two digital comparator flags describe the supply:

- `pf_ok` is high while the supply is above the power-fail threshold.
- `so_ok` is high while the supply is above the lower battery-switchover threshold.

When `pf_ok` drops, the block deselects itself: the bus is released, every strobe is ignored and no write can complete. When `so_ok` drops, `bat_sel` reports that the array is running on the backup source, and the stored contents are kept. When the supply comes back, the block keeps itself deselected for a fixed number of clock cycles and flags this with `recov_busy`. After reset it treats the supply as just restored, so it goes through one recovery interval before it accepts any access.

Top module: `pfsram_ctrl`

## Requirements
- R1: With chip select high (`ce_n`=1), `dq_oe` is 0 and no location is written, whatever `oe_n`, `we_n`, `addr` and `dq_in` do.
- R2: With `ce_n`=0 and `we_n`=0, the block is in write mode and stores `dq_in` at `addr`, for either level of `oe_n`.
- R3: With `ce_n`=0, `oe_n`=0 and `we_n`=1, `dq_oe` is 1 and `dq_out` equals the byte stored at `addr`.
- R4: With `ce_n`=0, `oe_n`=1 and `we_n`=1, `dq_oe` is 0.
- R5: A write starts at the later falling edge of `ce_n` and `we_n`. It completes at the earlier rising edge of the two, using the address and data last seen while both were low. A write may end by either strobe.
- R6: If `we_n` goes low while a read is driving the bus, `dq_oe` returns to 0.
- R7: While `pf_ok` is 0, `dq_oe` is 0 and writes are blocked. A write attempted in this state leaves memory unchanged.
- R8: While `so_ok` is 0, `bat_sel` is 1. Contents written before the power loss read back unchanged after recovery.
- R9: When `so_ok` returns to 1, `bat_sel` returns to 0. Once `pf_ok` is 1 again, `recov_busy` is 1 and the block stays deselected for RECOV_CYC cycles, then accepts accesses again. `recov_busy` and `bat_sel` are never 1 together.
- R10: If power fails during a write, no location other than the one being written changes. The addressed location holds either its old byte or the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pf_ok | input | 1 | Supply above power-fail threshold |
| so_ok | input | 1 | Supply above battery-switchover threshold |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address |
| dq_in | input | DW | Data from the bus |
| dq_out | output | DW | Read data (0 when not driving) |
| dq_oe | output | 1 | Bus drive enable for the pad |
| bat_sel | output | 1 | Backup source selected |
| recov_busy | output | 1 | Recovery interval running |

## Verification
On every cycle, the assertions check these properties:

- The bus is quiet in standby.
- A pending write disables the outputs.
- No drive and no array write occur while the block is protecting itself.
- An array write happens only in the cycle after the synchronised write strobe ends.
- The battery indicator follows a stable `so_ok`.
- Accesses are re-enabled only out of a recovery interval.

Only the bench scenarios can show the following:

- Data actually survives a power cycle.
- Writes attempted while protected leave memory unchanged.
- The recovery interval has the right length.
- A write cut short by power failure disturbs no neighbouring location.

// File: rtl/pfsram_pkg.sv
// Shared types for the power-fail protected SRAM.
package pfsram_pkg;

    // Supply condition as seen by the access logic.
    typedef enum logic [1:0] {
        PWR_NORMAL  = 2'd0,  // accesses allowed
        PWR_PROTECT = 2'd1,  // deselected, external supply, may be recovering
        PWR_BATTERY = 2'd2   // deselected, backup source selected
    } pwr_state_t;

endpackage

// File: rtl/pfsram_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes every bit of the bundle is stable long enough to be sampled
// coherently; it gives no cross-bit coherence guarantee beyond that.
module pfsram_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    // Shift the input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pfsram_pwr.sv
// Supply supervisor. It turns the two synchronised threshold flags into
// an access-allow signal, a backup-source indicator and a recovery-busy
// flag. Assumes so_ok is high whenever pf_ok is high (the switchover
// threshold lies below the power-fail threshold). Reset leaves it in
// PROTECT, so a full recovery interval follows every reset.
module pfsram_pwr
    import pfsram_pkg::*;
#(
    parameter int RECOV_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_ok,
    input  logic so_ok,
    output logic allow,
    output logic bat_sel,
    output logic recov_busy
);

    localparam int              CW   = $clog2(RECOV_CYC + 1);
    localparam logic [CW-1:0]   LAST = CW'(RECOV_CYC - 1);

    pwr_state_t    state, state_nxt;
    logic [CW-1:0] cnt;
    logic          counting;

    assign counting = (state == PWR_PROTECT) && pf_ok && so_ok;

    // Next-state selection from the supply flags and recovery count.
    always_comb begin
        state_nxt = state;
        case (state)
            PWR_NORMAL: begin
                if (!so_ok)      state_nxt = PWR_BATTERY;
                else if (!pf_ok) state_nxt = PWR_PROTECT;
            end
            PWR_PROTECT: begin
                if (!so_ok)                       state_nxt = PWR_BATTERY;
                else if (counting && cnt == LAST) state_nxt = PWR_NORMAL;
            end
            PWR_BATTERY: begin
                if (so_ok) state_nxt = PWR_PROTECT;
            end
            default: state_nxt = PWR_PROTECT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PWR_PROTECT;
        else        state <= state_nxt;
    end

    // Recovery counter: runs only while the supply is back but still protected.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt <= '0;
        else if (counting && state_nxt == PWR_PROTECT) cnt <= cnt + 1'b1;
        else                                          cnt <= '0;
    end

    assign allow      = (state == PWR_NORMAL);
    assign bat_sel    = (state == PWR_BATTERY);
    assign recov_busy = counting;

endmodule

// File: rtl/pfsram_bus.sv
// Strobe decoder and write tracker. It works on synchronised strobes:
// it decides when the bus is driven, follows the write window and
// issues one array write when the window closes. A window that closes
// because protection started issues no write.
module pfsram_bus #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_s,
    input  logic          oe_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] din_s,
    input  logic          allow,
    output logic          rd_en,
    output logic          wr_act,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata
);

    logic wr_act_q;

    assign wr_act = allow && !ce_s && !we_s;
    assign rd_en  = allow && !ce_s && !oe_s && we_s;

    // Track the write window and hold the latest address/data seen in it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_q  <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            wr_act_q <= wr_act;
            if (wr_act) begin
                mem_waddr <= addr_s;
                mem_wdata <= din_s;
            end
        end
    end

    // Commit on the closing edge of the window, only if still allowed.
    assign mem_we = wr_act_q && !wr_act && allow;

endmodule

// File: rtl/pfsram_array.sv
// Register-based byte array: one synchronous write port and one
// asynchronous read port. Contents are not reset, like a real SRAM.
module pfsram_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one byte per enabled cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pfsram_ctrl.sv
// Top level of the power-fail protected SRAM. It synchronises the pins,
// supervises the supply, decodes the access mode and holds the array.
// The bus is split into dq_in / dq_out / dq_oe so that the pad ring
// builds the tri-state driver.
module pfsram_ctrl #(
    parameter int AW        = 4,
    parameter int DW        = 8,
    parameter int SYNC_STG  = 2,
    parameter int RECOV_CYC = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_ok,
    input  logic          so_ok,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          bat_sel,
    output logic          recov_busy
);

    localparam int            PW      = 3 + AW + DW;
    localparam logic [PW-1:0] PIN_RST = {3'b111, {(AW + DW){1'b0}}};

    logic [PW-1:0] pin_q;
    logic [1:0]    flag_q;
    logic          ce_s, oe_s, we_s, pf_s, so_s;
    logic [AW-1:0] addr_s, mem_waddr;
    logic [DW-1:0] din_s, mem_wdata, rdata;
    logic          allow, rd_en, wr_act, mem_we;

    pfsram_sync #(.W(PW), .STAGES(SYNC_STG), .RST_VAL(PIN_RST)) u_pin_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ce_n, oe_n, we_n, addr, dq_in}),
        .q(pin_q)
    );

    pfsram_sync #(.W(2), .STAGES(SYNC_STG), .RST_VAL(2'b00)) u_flag_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pf_ok, so_ok}),
        .q(flag_q)
    );

    assign {ce_s, oe_s, we_s, addr_s, din_s} = pin_q;
    assign {pf_s, so_s}                      = flag_q;

    pfsram_pwr #(.RECOV_CYC(RECOV_CYC)) u_pwr (
        .clk(clk), .rst_n(rst_n),
        .pf_ok(pf_s), .so_ok(so_s),
        .allow(allow), .bat_sel(bat_sel), .recov_busy(recov_busy)
    );

    pfsram_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s),
        .addr_s(addr_s), .din_s(din_s), .allow(allow),
        .rd_en(rd_en), .wr_act(wr_act), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    pfsram_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .we(mem_we),
        .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(addr_s), .rdata(rdata)
    );

    assign dq_oe  = rd_en;
    assign dq_out = rd_en ? rdata : '0;

endmodule

// File: rtl/pfsram_ctrl_chk.sv
// Property checker for pfsram_ctrl, attached to it with a bind.
module pfsram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_s,
    input logic oe_s,
    input logic we_s,
    input logic so_s,
    input logic allow,
    input logic dq_oe,
    input logic wr_act,
    input logic mem_we,
    input logic bat_sel,
    input logic recov_busy
);

    AST_STANDBY_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_s |-> !dq_oe);                                               // R1

    AST_STANDBY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_s && $past(ce_s) && $past(rst_n)) |-> !mem_we);             // R1

    AST_READ_ONLY_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (we_s && !oe_s && !ce_s));                            // R6

    AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(wr_act) && !wr_act));                         // R5

    AST_PROTECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !allow |-> (!dq_oe && !mem_we));                                // R7

    AST_BATTERY_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!so_s && !$past(so_s) && $past(rst_n)) |-> bat_sel);           // R8

    AST_BATTERY_OFF_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (so_s && $past(so_s) && $past(rst_n)) |-> !bat_sel);            // R9

    AST_NO_BAT_IN_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        !(bat_sel && recov_busy));                                      // R9

    AST_ALLOW_AFTER_RECOV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(allow) |-> $past(recov_busy));                            // R9

endmodule

bind pfsram_ctrl pfsram_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .ce_s(ce_s), .oe_s(oe_s), .we_s(we_s), .so_s(so_s),
    .allow(allow), .dq_oe(dq_oe), .wr_act(wr_act), .mem_we(mem_we),
    .bat_sel(bat_sel), .recov_busy(recov_busy)
);

// File: tb/pfsram_ctrl_tb.sv
`timescale 1ns/1ps
module pfsram_ctrl_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int RECOV = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pf_ok, so_ok, ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe, bat_sel, recov_busy;

    logic [DW-1:0] model [DEPTH];
    int            total = 0;
    int            fails = 0;
    bit            done  = 0;

    always #2 clk = ~clk;

    pfsram_ctrl #(.AW(AW), .DW(DW), .RECOV_CYC(RECOV)) u_dut (
        .clk(clk), .rst_n(rst_n), .pf_ok(pf_ok), .so_ok(so_ok),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .bat_sel(bat_sel),
        .recov_busy(recov_busy)
    );

    // Expected bus drive from the pin levels and supply condition.
    function automatic bit exp_drive(bit ce, bit oe, bit we, bit pwr);
        return pwr && !ce && !oe && we;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        tick(3);
    endtask

    // Write cycle: the start order and the ending strobe are selectable.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit ce_last, input bit end_by_ce,
                            input bit oe_v, input bit upd);
        addr = a; dq_in = d; oe_n = oe_v;
        if (ce_last) begin we_n = 1'b0; tick(2); ce_n = 1'b0; end
        else         begin ce_n = 1'b0; tick(2); we_n = 1'b0; end
        tick(4);
        if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
        tick(3);
        dq_in = ~d;
        idle();
        if (upd) model[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string tag);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick(4);
        chk(dq_oe === 1'b1, tag, 16'(dq_oe), 16'd1);
        chk(dq_out === model[a], tag, 16'(dq_out), 16'(model[a]));
        idle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; pf_ok = 1'b1; so_ok = 1'b1;
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; dq_in = '0;
        tick(5);
        // Reset state.
        chk(dq_oe === 1'b0 && bat_sel === 1'b0 && recov_busy === 1'b0,
            "R1 reset", {13'd0, dq_oe, bat_sel, recov_busy}, 16'd0);
        rst_n = 1'b1;
        tick(4);
        chk(recov_busy === 1'b1, "R9 recovery after reset", 16'(recov_busy), 16'd1);
        tick(RECOV + 4);
        chk(recov_busy === 1'b0, "R9 recovery ends", 16'(recov_busy), 16'd0);

        // R2: fill every location, alternating the oe_n level.
        for (int i = 0; i < DEPTH; i++)
            do_write(AW'(i), DW'(8'h30 + i * 7), 1'b0, 1'b0, 1'(i), 1'b1);
        for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R2/R3 fill readback");

        // R5: the write opens on the later falling edge and closes on the earlier rising edge.
        do_write(4'd2, 8'hA1, 1'b1, 1'b1, 1'b1, 1'b1);
        do_read(4'd2, "R5 ce last, ends by ce");
        do_write(4'd3, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b1);
        do_read(4'd3, "R5 we last, ends by we");

        // R1: strobes toggled under chip select high write nothing.
        addr = 4'd3; dq_in = 8'h5A; ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0;
        tick(4);
        chk(dq_oe === 1'b0, "R1 standby bus", 16'(dq_oe), 16'd0);
        we_n = 1'b1; tick(3); idle();
        do_read(4'd3, "R1 standby no write");

        // R4: active but quiet.
        addr = 4'd3; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        tick(4);
        chk(dq_oe === 1'b0, "R4 quiet bus", 16'(dq_oe), 16'd0);
        idle();

        // R6: we_n falling during a read turns the outputs off.
        addr = 4'd6; dq_in = 8'hC6; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        tick(4);
        chk(dq_oe === 1'b1, "R6 read before", 16'(dq_oe), 16'd1);
        we_n = 1'b0; tick(4);
        chk(dq_oe === 1'b0, "R6 outputs off", 16'(dq_oe), 16'd0);
        we_n = 1'b1; tick(3); idle();
        model[6] = 8'hC6;
        do_read(4'd6, "R6 write via oe low");

        // R7/R8/R9: power loss, battery, recovery.
        pf_ok = 1'b0; tick(4);
        addr = 4'd9; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tick(4);
        chk(dq_oe === 1'b0, "R7 no read when failing", 16'(dq_oe), 16'd0);
        idle();
        do_write(4'd9, 8'hEE, 1'b0, 1'b0, 1'b1, 1'b0);
        so_ok = 1'b0; tick(4);
        chk(bat_sel === 1'b1, "R8 battery selected", 16'(bat_sel), 16'd1);
        so_ok = 1'b1; tick(4);
        chk(bat_sel === 1'b0, "R9 battery released", 16'(bat_sel), 16'd0);
        addr = 4'd9; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        pf_ok = 1'b1; tick(4);
        chk(recov_busy === 1'b1, "R9 recovering", 16'(recov_busy), 16'd1);
        chk(dq_oe === 1'b0, "R9 deselected in recovery", 16'(dq_oe), 16'd0);
        tick(RECOV / 2);
        chk(dq_oe === 1'b0, "R9 still deselected", 16'(dq_oe), 16'd0);
        tick(RECOV / 2 + 4);
        chk(recov_busy === 1'b0, "R9 recovery done", 16'(recov_busy), 16'd0);
        chk(dq_oe === 1'b1 && dq_out === model[9], "R7/R8 data kept, blocked write",
            16'(dq_out), 16'(model[9]));
        idle();

        // R10: power fails in the middle of a write.
        addr = 4'd5; dq_in = 8'h77; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        tick(4);
        pf_ok = 1'b0; tick(4);
        we_n = 1'b1; ce_n = 1'b1; tick(3);
        pf_ok = 1'b1; tick(RECOV + 8);
        for (int i = 0; i < DEPTH; i++) begin
            addr = AW'(i); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
            tick(4);
            if (i == 5) begin
                chk(dq_out === model[5] || dq_out === 8'h77, "R10 addressed byte",
                    16'(dq_out), 16'(model[5]));
                model[5] = dq_out;
            end else begin
                chk(dq_out === model[i], "R10 neighbour intact",
                    16'(dq_out), 16'(model[i]));
            end
            idle();
        end

        // Random mix of writes, reads and pin probes.
        for (int it = 0; it < 150; it++) begin
            int op = int'($urandom_range(0, 2));
            logic [AW-1:0] a = AW'($urandom);
            v = DW'($urandom);
            if (op == 0) begin
                do_write(a, v, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1);
            end else if (op == 1) begin
                do_read(a, "R3 random read");
            end else begin
                bit c = 1'($urandom);
                bit o = 1'($urandom);
                bit w = c ? 1'($urandom) : 1'b1;
                addr = a; dq_in = v; ce_n = c; oe_n = o; we_n = w;
                tick(4);
                chk(dq_oe === exp_drive(c, o, w, 1'b1),
                    c ? "R1 random probe" : (o ? "R4 random probe" : "R3 random probe"),
                    16'(dq_oe), 16'(exp_drive(c, o, w, 1'b1)));
                if (exp_drive(c, o, w, 1'b1))
                    chk(dq_out === model[a], "R3 random probe data",
                        16'(dq_out), 16'(model[a]));
                idle();
            end
        end
        for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R2 final sweep");

        finish_run();
    end

endmodule